// File: doc/BRIEF.md
# Ordered Store Queue with Load Address Disambiguation

This block holds the stores that a processor has issued but not yet committed, kept in program order. A store takes a slot at issue and receives its position in the queue. Its address and its value are written into that slot later, separately, whenever each one becomes known. When the store reaches commit, it leaves from the head of the queue and its address and data are written to memory. Because stores write memory only at commit and strictly in order, memory never needs a write-after-read or write-after-write check.

Each load records the queue's allocation position when it issues. That position separates the stores older than the load from the stores younger than it. When the load later presents its address, the block searches only the older stores and returns one verdict, one cycle later:

- stall, if an older store still has an unknown address;
- the value of the youngest older store to the same address, if that value is known;
- the producer tag of that store's value, if the value is not yet known;
- go to memory, if no older store matches.

A flush discards every uncommitted store.

Top module: `sq_disambig`

## Requirements
- R1: After reset the queue is empty: alloc_ready is 1, head_valid is 0, alloc_pos is 0 and ld_rsp_valid is 0.
- R2: alloc_pos is a pointer one bit wider than the slot index, and its low bits are the slot a store receives. It rises by one for each accepted allocation and wraps modulo 2*DEPTH. alloc_ready is 0 while DEPTH stores are held, and an allocation attempted then is ignored.
- R3: Address and data updates name a slot and fill in independently. An update to a slot that holds no store is ignored, and a newly allocated store starts with both address and data unknown.
- R4: A lookup in cycle N produces ld_rsp_valid in cycle N+1, with a verdict computed from the queue contents at the start of cycle N. ld_rsp_kind encodes the verdict as 0 = memory, 1 = forward, 2 = tag, 3 = stall.
- R5: The verdict is stall when any store older than the load still has an unknown address, even if another older store matches.
- R6: When the youngest matching older store has its data, the verdict is forward and ld_rsp_data is that data.
- R7: When the youngest matching older store lacks its data, the verdict is tag and ld_rsp_tag is the tag given at that store's allocation, even if an older match has data.
- R8: The verdict is memory when no older store matches. Stores at or after ld_pos are not considered, including stores whose address is unknown.
- R9: head_valid is 1 when the oldest store has both its address and its data, and head_addr and head_data show that store. retire_valid removes the oldest store only while head_valid is 1; otherwise it is ignored.
- R10: Stores retire in allocation order, across the wrap of the slot index.
- R11: flush discards all held stores. alloc_ready then reads 1, head_valid reads 0, alloc_pos returns to the head position, and later lookups see no older stores. An allocation in the same cycle as flush is dropped.
- R12: The address compare uses every address bit, so two addresses that differ in any one bit do not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all uncommitted stores |
| alloc_valid | input | 1 | Allocate a slot for a new store |
| alloc_tag | input | 6 | Producer tag of the new store's value |
| alloc_ready | output | 1 | A slot is free |
| alloc_pos | output | 4 | Next allocation pointer; its low bits are the slot index |
| addr_valid | input | 1 | Write a store address |
| addr_idx | input | 3 | Slot receiving the address |
| addr_value | input | 32 | Store address |
| data_valid | input | 1 | Write a store value |
| data_idx | input | 3 | Slot receiving the value |
| data_value | input | 32 | Store value |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | 32 | Load address |
| ld_pos | input | 4 | alloc_pos captured when the load issued |
| ld_rsp_valid | output | 1 | Verdict present |
| ld_rsp_kind | output | 2 | 0 memory, 1 forward, 2 tag, 3 stall |
| ld_rsp_data | output | 32 | Forwarded value (0 unless forward) |
| ld_rsp_tag | output | 6 | Producer tag (0 unless tag) |
| retire_valid | input | 1 | Commit the oldest store |
| head_valid | output | 1 | Oldest store is complete |
| head_addr | output | 32 | Oldest store's address |
| head_data | output | 32 | Oldest store's value |

## Verification
A wrong head or tail pointer shows up at once in alloc_pos, alloc_ready and the head outputs. It also makes the next lookup count the wrong stores as older, so a load verdict comes back as stall or memory where the other was due, one cycle after the lookup. A stale address-known or data-known flag turns a forward into a tag, or lets a load skip a stall it needs; the scenarios probe each flag directly through a lookup made right after the update. A broken youngest-match priority appears only when two older stores share one address, so those cases are set up on purpose, including across the index wrap.

// File: rtl/sq_pkg.sv
package sq_pkg;
    parameter int SQ_AW = 32;
    parameter int SQ_DW = 32;
    parameter int SQ_TW = 6;

    typedef enum logic [1:0] {
        LD_MEM   = 2'd0,
        LD_FWD   = 2'd1,
        LD_TAG   = 2'd2,
        LD_STALL = 2'd3
    } ld_kind_e;

    typedef struct packed {
        logic             addr_ok;
        logic [SQ_AW-1:0] addr;
        logic             data_ok;
        logic [SQ_DW-1:0] data;
        logic [SQ_TW-1:0] tag;
    } sq_entry_t;
endpackage

// File: rtl/sq_ptr_ctrl.sv
module sq_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH),
    localparam int PW = IW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic             flush,
    input  logic             retire_fire,
    output logic             alloc_ready,
    output logic             alloc_fire,
    output logic [PW-1:0]    head_ptr,
    output logic [PW-1:0]    tail_ptr,
    output logic [PW-1:0]    count,
    output logic [DEPTH-1:0] live
);
    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
    } ptr_t;

    ptr_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        count       = st_q.tail - st_q.head;
        alloc_ready = (count != PW'(DEPTH));
        alloc_fire  = alloc_valid && alloc_ready && !flush;
        if (retire_fire) begin
            st_d.head = st_q.head + PW'(1);
        end
        if (flush) begin
            st_d.tail = st_d.head;
        end else if (alloc_fire) begin
            st_d.tail = st_q.tail + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_ptr = st_q.head;
    assign tail_ptr = st_q.tail;

    for (genvar i = 0; i < DEPTH; i++) begin : g_live
        logic [IW-1:0] off;
        assign off     = IW'(i) - st_q.head[IW-1:0];
        assign live[i] = ({1'b0, off} < count);
    end
endmodule

// File: rtl/sq_entry_store.sv
module sq_entry_store
    import sq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_we,
    input  logic [IW-1:0]          alloc_idx,
    input  logic [SQ_TW-1:0]       alloc_tag,
    input  logic                   addr_we,
    input  logic [IW-1:0]          addr_idx,
    input  logic [SQ_AW-1:0]       addr_val,
    input  logic                   data_we,
    input  logic [IW-1:0]          data_idx,
    input  logic [SQ_DW-1:0]       data_val,
    input  logic [DEPTH-1:0]       live,
    output sq_entry_t [DEPTH-1:0]  ents
);
    sq_entry_t [DEPTH-1:0] ents_d, ents_q;

    always_comb begin
        ents_d = ents_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (alloc_we && alloc_idx == IW'(i)) begin
                ents_d[i].addr_ok = 1'b0;
                ents_d[i].addr    = '0;
                ents_d[i].data_ok = 1'b0;
                ents_d[i].data    = '0;
                ents_d[i].tag     = alloc_tag;
            end else begin
                if (addr_we && addr_idx == IW'(i) && live[i]) begin
                    ents_d[i].addr_ok = 1'b1;
                    ents_d[i].addr    = addr_val;
                end
                if (data_we && data_idx == IW'(i) && live[i]) begin
                    ents_d[i].data_ok = 1'b1;
                    ents_d[i].data    = data_val;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ents_q <= '0;
        end else begin
            ents_q <= ents_d;
        end
    end

    assign ents = ents_q;
endmodule

// File: rtl/sq_age_search.sv
module sq_age_search
    import sq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH),
    localparam int PW = IW + 1
) (
    input  sq_entry_t [DEPTH-1:0] ents,
    input  logic [DEPTH-1:0]      live,
    input  logic [PW-1:0]         head_ptr,
    input  logic [SQ_AW-1:0]      ld_addr,
    input  logic [PW-1:0]         ld_pos,
    output ld_kind_e              kind,
    output logic [SQ_DW-1:0]      fwd_data,
    output logic [SQ_TW-1:0]      fwd_tag
);
    logic [PW-1:0] lim;
    logic          any_unknown;
    logic          hit;
    logic [IW-1:0] hit_idx;
    logic [IW-1:0] idx;

    always_comb begin
        lim         = ld_pos - head_ptr;
        any_unknown = 1'b0;
        hit         = 1'b0;
        hit_idx     = '0;
        idx         = '0;
        // walk oldest to youngest so the last hit is the youngest one
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_ptr[IW-1:0] + IW'(k);
            if (live[idx] && (PW'(k) < lim)) begin
                if (!ents[idx].addr_ok) begin
                    any_unknown = 1'b1;
                end else if (ents[idx].addr == ld_addr) begin
                    hit     = 1'b1;
                    hit_idx = idx;
                end
            end
        end

        kind     = LD_MEM;
        fwd_data = '0;
        fwd_tag  = '0;
        if (any_unknown) begin
            kind = LD_STALL;
        end else if (hit) begin
            if (ents[hit_idx].data_ok) begin
                kind     = LD_FWD;
                fwd_data = ents[hit_idx].data;
            end else begin
                kind    = LD_TAG;
                fwd_tag = ents[hit_idx].tag;
            end
        end
    end
endmodule

// File: rtl/sq_disambig.sv
module sq_disambig
    import sq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH),
    localparam int PW = IW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             alloc_valid,
    input  logic [SQ_TW-1:0] alloc_tag,
    output logic             alloc_ready,
    output logic [PW-1:0]    alloc_pos,
    input  logic             addr_valid,
    input  logic [IW-1:0]    addr_idx,
    input  logic [SQ_AW-1:0] addr_value,
    input  logic             data_valid,
    input  logic [IW-1:0]    data_idx,
    input  logic [SQ_DW-1:0] data_value,
    input  logic             ld_valid,
    input  logic [SQ_AW-1:0] ld_addr,
    input  logic [PW-1:0]    ld_pos,
    output logic             ld_rsp_valid,
    output logic [1:0]       ld_rsp_kind,
    output logic [SQ_DW-1:0] ld_rsp_data,
    output logic [SQ_TW-1:0] ld_rsp_tag,
    input  logic             retire_valid,
    output logic             head_valid,
    output logic [SQ_AW-1:0] head_addr,
    output logic [SQ_DW-1:0] head_data
);
    typedef struct packed {
        logic             valid;
        ld_kind_e         kind;
        logic [SQ_DW-1:0] data;
        logic [SQ_TW-1:0] tag;
    } rsp_t;

    logic                  alloc_fire;
    logic                  retire_fire;
    logic [PW-1:0]         head_ptr;
    logic [PW-1:0]         tail_ptr;
    logic [PW-1:0]         count;
    logic [DEPTH-1:0]      live;
    sq_entry_t [DEPTH-1:0] ents;
    sq_entry_t             head_ent;
    ld_kind_e              srch_kind;
    logic [SQ_DW-1:0]      srch_data;
    logic [SQ_TW-1:0]      srch_tag;
    rsp_t                  rsp_d, rsp_q;

    sq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_valid (alloc_valid),
        .flush       (flush),
        .retire_fire (retire_fire),
        .alloc_ready (alloc_ready),
        .alloc_fire  (alloc_fire),
        .head_ptr    (head_ptr),
        .tail_ptr    (tail_ptr),
        .count       (count),
        .live        (live)
    );

    sq_entry_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_we  (alloc_fire),
        .alloc_idx (tail_ptr[IW-1:0]),
        .alloc_tag (alloc_tag),
        .addr_we   (addr_valid),
        .addr_idx  (addr_idx),
        .addr_val  (addr_value),
        .data_we   (data_valid),
        .data_idx  (data_idx),
        .data_val  (data_value),
        .live      (live),
        .ents      (ents)
    );

    sq_age_search #(.DEPTH(DEPTH)) u_search (
        .ents     (ents),
        .live     (live),
        .head_ptr (head_ptr),
        .ld_addr  (ld_addr),
        .ld_pos   (ld_pos),
        .kind     (srch_kind),
        .fwd_data (srch_data),
        .fwd_tag  (srch_tag)
    );

    assign head_ent    = ents[head_ptr[IW-1:0]];
    assign head_valid  = (count != '0) && head_ent.addr_ok && head_ent.data_ok;
    assign head_addr   = head_ent.addr;
    assign head_data   = head_ent.data;
    assign retire_fire = retire_valid && head_valid;
    assign alloc_pos   = tail_ptr;

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = ld_valid;
        if (ld_valid) begin
            rsp_d.kind = srch_kind;
            rsp_d.data = srch_data;
            rsp_d.tag  = srch_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign ld_rsp_valid = rsp_q.valid;
    assign ld_rsp_kind  = rsp_q.kind;
    assign ld_rsp_data  = rsp_q.data;
    assign ld_rsp_tag   = rsp_q.tag;
endmodule

// File: rtl/sq_disambig_chk.sv
module sq_disambig_chk
    import sq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH),
    localparam int PW = IW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          alloc_valid,
    input logic          alloc_ready,
    input logic [PW-1:0] alloc_pos,
    input logic          ld_valid,
    input logic          ld_rsp_valid,
    input logic [1:0]    ld_rsp_kind,
    input logic          retire_valid,
    input logic          head_valid
);
    logic flushed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flushed_q <= 1'b0;
        end else begin
            flushed_q <= flush;
        end
    end

    AST_ALLOC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid && alloc_ready && !flush |=> alloc_pos == $past(alloc_pos) + PW'(1)); // R2
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid && !alloc_ready && !flush |=> alloc_pos == $past(alloc_pos)); // R2
    AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> ld_rsp_valid); // R4
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !ld_rsp_valid); // R4
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid && !retire_valid && !flush |=> head_valid); // R9
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> alloc_ready && !head_valid); // R11
    AST_MEM_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flushed_q && ld_valid |=> ld_rsp_kind == 2'd0); // R11
endmodule

bind sq_disambig sq_disambig_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .alloc_valid  (alloc_valid),
    .alloc_ready  (alloc_ready),
    .alloc_pos    (alloc_pos),
    .ld_valid     (ld_valid),
    .ld_rsp_valid (ld_rsp_valid),
    .ld_rsp_kind  (ld_rsp_kind),
    .retire_valid (retire_valid),
    .head_valid   (head_valid)
);

// File: tb/sq_disambig_tb.sv
module sq_disambig_tb;
    localparam int K_MEM = 0, K_FWD = 1, K_TAG = 2, K_STALL = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [5:0]  alloc_tag = '0;
    logic        alloc_ready;
    logic [3:0]  alloc_pos;
    logic        addr_valid = 1'b0;
    logic [2:0]  addr_idx = '0;
    logic [31:0] addr_value = '0;
    logic        data_valid = 1'b0;
    logic [2:0]  data_idx = '0;
    logic [31:0] data_value = '0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_addr = '0;
    logic [3:0]  ld_pos = '0;
    logic        ld_rsp_valid;
    logic [1:0]  ld_rsp_kind;
    logic [31:0] ld_rsp_data;
    logic [5:0]  ld_rsp_tag;
    logic        retire_valid = 1'b0;
    logic        head_valid;
    logic [31:0] head_addr;
    logic [31:0] head_data;

    int n_checks = 0;
    int n_fails = 0;

    typedef struct {
        int          kind;
        logic [31:0] data;
        logic [5:0]  tag;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    sq_disambig u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag),
        .alloc_ready(alloc_ready), .alloc_pos(alloc_pos),
        .addr_valid(addr_valid), .addr_idx(addr_idx), .addr_value(addr_value),
        .data_valid(data_valid), .data_idx(data_idx), .data_value(data_value),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_pos(ld_pos),
        .ld_rsp_valid(ld_rsp_valid), .ld_rsp_kind(ld_rsp_kind),
        .ld_rsp_data(ld_rsp_data), .ld_rsp_tag(ld_rsp_tag),
        .retire_valid(retire_valid), .head_valid(head_valid),
        .head_addr(head_addr), .head_data(head_data)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: pop expected verdicts as the design produces them
    always @(negedge clk) begin
        if (rst_n && ld_rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected response", 64'(ld_rsp_kind), 64'(0));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(ld_rsp_kind == 2'(e.kind), e.req, 64'(ld_rsp_kind), 64'(e.kind));
                if (e.kind == K_FWD)
                    check(ld_rsp_data == e.data, e.req, 64'(ld_rsp_data), 64'(e.data));
                if (e.kind == K_TAG)
                    check(ld_rsp_tag == e.tag, e.req, 64'(ld_rsp_tag), 64'(e.tag));
            end
        end
    end

    task automatic do_alloc(input logic [5:0] tag);
        alloc_valid = 1'b1; alloc_tag = tag;
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic do_addr(input logic [2:0] idx, input logic [31:0] a);
        addr_valid = 1'b1; addr_idx = idx; addr_value = a;
        @(negedge clk);
        addr_valid = 1'b0;
    endtask

    task automatic do_data(input logic [2:0] idx, input logic [31:0] d);
        data_valid = 1'b1; data_idx = idx; data_value = d;
        @(negedge clk);
        data_valid = 1'b0;
    endtask

    task automatic do_retire();
        retire_valid = 1'b1;
        @(negedge clk);
        retire_valid = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] a, input logic [3:0] pos, input int kind,
                          input logic [31:0] d, input logic [5:0] tag, input string req);
        exp_t e;
        e.kind = kind; e.data = d; e.tag = tag; e.req = req;
        exp_q.push_back(e);
        ld_valid = 1'b1; ld_addr = a; ld_pos = pos;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(alloc_ready == 1'b1, "R1 alloc_ready", 64'(alloc_ready), 64'(1));
        check(head_valid == 1'b0, "R1 head_valid", 64'(head_valid), 64'(0));
        check(alloc_pos == 4'd0, "R1 alloc_pos", 64'(alloc_pos), 64'(0));
        check(ld_rsp_valid == 1'b0, "R1 ld_rsp_valid", 64'(ld_rsp_valid), 64'(0));

        do_alloc(6'd5); do_alloc(6'd6); do_alloc(6'd7);
        check(alloc_pos == 4'd3, "R2 alloc_pos after three", 64'(alloc_pos), 64'(3));
        do_addr(3'd5, 32'h500); // R3 slot 5 holds no store yet
        lookup(32'h100, 4'd3, K_STALL, 0, 0, "R5 all addresses unknown");
        do_addr(3'd0, 32'h100);
        do_addr(3'd1, 32'h200);
        lookup(32'h100, 4'd3, K_STALL, 0, 0, "R5 slot 2 unknown despite match");
        lookup(32'h100, 4'd2, K_TAG, 0, 6'd5, "R7 match without data");
        lookup(32'h100, 4'd1, K_TAG, 0, 6'd5, "R7 single older store");
        lookup(32'h100, 4'd0, K_MEM, 0, 0, "R8 no older store");
        lookup(32'h300, 4'd2, K_MEM, 0, 0, "R8 younger unknown ignored");
        do_data(3'd0, 32'hAAAA);
        lookup(32'h100, 4'd2, K_FWD, 32'hAAAA, 0, "R6 forward");
        do_addr(3'd2, 32'h100);
        lookup(32'h100, 4'd3, K_TAG, 0, 6'd7, "R7 youngest match lacks data");
        do_data(3'd2, 32'hCCCC);
        lookup(32'h100, 4'd3, K_FWD, 32'hCCCC, 0, "R6 youngest match forwards");
        lookup(32'h8000_0100, 4'd3, K_MEM, 0, 0, "R12 top bit differs");
        lookup(32'h101, 4'd3, K_MEM, 0, 0, "R12 low bit differs");

        do_alloc(6'd9); do_alloc(6'd10); do_alloc(6'd11);
        lookup(32'h500, 4'd6, K_STALL, 0, 0, "R3 early update not kept");
        do_alloc(6'd12); do_alloc(6'd13);
        check(alloc_ready == 1'b0, "R2 full", 64'(alloc_ready), 64'(0));
        check(alloc_pos == 4'd8, "R2 pos when full", 64'(alloc_pos), 64'(8));
        do_alloc(6'd14);
        check(alloc_pos == 4'd8, "R2 alloc while full ignored", 64'(alloc_pos), 64'(8));

        check(head_valid == 1'b1, "R9 head complete", 64'(head_valid), 64'(1));
        check(head_addr == 32'h100, "R9 head_addr", 64'(head_addr), 64'(32'h100));
        check(head_data == 32'hAAAA, "R9 head_data", 64'(head_data), 64'(32'hAAAA));
        do_retire();
        check(head_valid == 1'b0, "R9 next head incomplete", 64'(head_valid), 64'(0));
        do_retire(); // R9 must be ignored
        do_data(3'd1, 32'hBBBB);
        check(head_valid == 1'b1, "R9 retire ignored", 64'(head_valid), 64'(1));
        check(head_data == 32'hBBBB, "R10 order slot 1", 64'(head_data), 64'(32'hBBBB));
        check(head_addr == 32'h200, "R10 order addr", 64'(head_addr), 64'(32'h200));
        do_retire();
        check(head_data == 32'hCCCC, "R10 order slot 2", 64'(head_data), 64'(32'hCCCC));
        check(alloc_ready == 1'b1, "R2 ready after retire", 64'(alloc_ready), 64'(1));

        do_alloc(6'd15);
        check(alloc_pos == 4'd9, "R2 wrap pointer", 64'(alloc_pos), 64'(9));
        for (int i = 3; i < 8; i++) do_addr(3'(i), 32'h400 + 32'((i - 3) * 16));
        do_addr(3'd0, 32'h100);
        do_data(3'd0, 32'hDDDD);
        lookup(32'h100, 4'd9, K_FWD, 32'hDDDD, 0, "R10 youngest across wrap");
        lookup(32'h100, 4'd8, K_FWD, 32'hCCCC, 0, "R10 wrapped store is younger");
        lookup(32'h100, 4'd3, K_FWD, 32'hCCCC, 0, "R8 only slot 2 older");
        lookup(32'h430, 4'd9, K_TAG, 0, 6'd12, "R7 tag of slot 6");

        flush = 1'b1; alloc_valid = 1'b1; alloc_tag = 6'd20;
        @(negedge clk);
        flush = 1'b0; alloc_valid = 1'b0;
        check(alloc_ready == 1'b1, "R11 ready", 64'(alloc_ready), 64'(1));
        check(head_valid == 1'b0, "R11 head empty", 64'(head_valid), 64'(0));
        check(alloc_pos == 4'd2, "R11 pos back to head", 64'(alloc_pos), 64'(2));
        lookup(32'h100, 4'd9, K_MEM, 0, 0, "R11 no stores after flush");
        do_alloc(6'd21);
        check(alloc_pos == 4'd3, "R11 alloc after flush", 64'(alloc_pos), 64'(3));
        lookup(32'h100, 4'd3, K_STALL, 0, 0, "R3 fresh store address unknown");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4 all responses seen", 64'(exp_q.size()), 64'(0));
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule